// File: doc/BRIEF.md
# Password-Gated Write Protection Register

This block guards a small group of clock and power configuration bits against stray software writes. It sits on a plain synchronous register bus with a write strobe, a read strobe, a one-bit address and byte-wide data. Address 0 holds the key/control register and address 1 holds the guarded configuration byte. While the scheme is armed, the guarded byte ignores writes until software stores the unlock key in the key field of the control register. Access then stays open for a limited run of clock cycles and locks again by itself, unless software relocks it sooner with the lock key.

The control register has a two-bit scheme mode. Any non-zero mode arms the scheme. Mode 00 disarms it. The mode changes only on a write that carries its own dedicated key in the same byte. A status bit always shows whether guarded writes are blocked at that moment. The guarded byte drives the divider fields, the watchdog enable and the two power-mode enables as outputs.

Top module: `wprot_reg`

## Requirements
- R1: After reset, the control register (address 0) reads 0x07 (mode 11, status 1, key field 0), and the guarded byte (address 1) reads 0x00.
- R2: Control read-back is {5'b00000, status, mode[1:0]}, so the key field always reads zero. rdata is 0x00 whenever rd_en is low, and it reflects the current state in the same cycle.
- R3: A control write with key field bits[7:3] = 5'b10011, made while the mode is non-zero, clears the status bit from the next cycle. A guarded write at any of the WINDOW (default 32) clock edges after that write is accepted.
- R4: If no lock key arrives, the status bit returns to 1 exactly WINDOW cycles after the unlock write. A guarded write at the edge WINDOW+1 cycles after the unlock write is ignored.
- R5: Repeating the unlock key while access is open restarts the full WINDOW-cycle count from the repeated write.
- R6: A control write with key field 5'b10110 is not special; a control write with key field 5'b10101 sets the status bit (when the mode is non-zero) from the next cycle.
- R7: The mode takes wdata[1:0] only on a control write whose key field is 5'b11000. A control write with any other key field leaves the mode unchanged.
- R8: With mode 00 the status bit reads 0 and guarded writes are always accepted. Modes 01, 10 and 11 all arm the scheme.
- R9: While the status bit is 1, writes to the guarded byte are ignored. Guarded byte layout: [7:5] N divider, [4:3] K divider, [2] watchdog enable, [1] slow-down enable, [0] power-down enable.
- R10: Key field values other than 11000, 10011 and 10101 change neither the mode nor the access state.
- R11: The unlock key written while the mode is 00 starts no window. After the mode is re-armed, the status bit reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | 0 = key/control register, 1 = guarded byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| ndiv | output | 3 | N divider field |
| kdiv | output | 2 | K divider field |
| wdog_en | output | 1 | Watchdog enable |
| sd_en | output | 1 | Slow-down enable |
| pd_en | output | 1 | Power-down enable |
| locked | output | 1 | Status: 1 when guarded writes are blocked |
| scheme_mode | output | 2 | Current scheme mode |

## Verification
The hardest case to reach is the exact edge of the timed window. That means a guarded write landing on the last accepted edge or on the first blocked one, and an unlock repeated late in a window that is about to expire. Random traffic almost never lines these up, so directed sequences count idle cycles after an unlock and place writes at edges WINDOW and WINDOW+1. Random mixes of keys, mode changes and guarded writes, weighted toward the key patterns, then cover the interleavings, including re-arming after a disarmed unlock attempt.

// File: rtl/wprot_reg.sv
module wprot_reg #(
  parameter int WINDOW = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [2:0] ndiv,
  output logic [1:0] kdiv,
  output logic       wdog_en,
  output logic       sd_en,
  output logic       pd_en,
  output logic       locked,
  output logic [1:0] scheme_mode
);
  localparam int CW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [4:0] KEY_MODE   = 5'b11000;
  localparam logic [4:0] KEY_UNLOCK = 5'b10011;
  localparam logic [4:0] KEY_LOCK   = 5'b10101;

  logic [1:0]    mode_q;
  logic          open_q;
  logic [CW-1:0] left_q;
  logic [7:0]    guard_q;

  wire [4:0] key    = wdata[7:3];
  wire       ctl_wr = wr_en && !addr;
  wire       grd_wr = wr_en && addr;
  wire       armed  = mode_q != 2'b00;

  assign locked = armed && !open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 2'b11;
      open_q  <= 1'b0;
      left_q  <= '0;
      guard_q <= 8'h00;
    end else begin
      if (open_q) begin
        if (left_q == '0) open_q <= 1'b0;
        else              left_q <= left_q - 1'b1;
      end
      if (ctl_wr) begin
        if (key == KEY_MODE) mode_q <= wdata[1:0];
        if (key == KEY_UNLOCK && armed) begin
          open_q <= 1'b1;
          left_q <= CW'(WINDOW - 1);
        end
        if (key == KEY_LOCK) open_q <= 1'b0;
      end
      if (grd_wr && !locked) guard_q <= wdata;
    end
  end

  assign rdata = !rd_en ? 8'h00 :
                 addr   ? guard_q : {5'b00000, locked, mode_q};

  assign ndiv        = guard_q[7:5];
  assign kdiv        = guard_q[4:3];
  assign wdog_en     = guard_q[2];
  assign sd_en       = guard_q[1];
  assign pd_en       = guard_q[0];
  assign scheme_mode = mode_q;
endmodule

// File: rtl/wprot_reg_chk.sv
module wprot_reg_chk #(
  parameter int WINDOW = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       addr,
  input logic [7:0] wdata,
  input logic [2:0] ndiv,
  input logic [1:0] kdiv,
  input logic       wdog_en,
  input logic       sd_en,
  input logic       pd_en,
  input logic       locked,
  input logic [1:0] scheme_mode
);
  localparam int SW = $clog2(WINDOW + 2) + 1;
  wire [7:0] guard = {ndiv, kdiv, wdog_en, sd_en, pd_en};
  wire       ctl_wr = wr_en && !addr;
  logic [SW-1:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since <= SW'(WINDOW + 1);
    else if (ctl_wr && wdata[7:3] == 5'b10011 && scheme_mode != 2'b00) since <= '0;
    else if (since < SW'(WINDOW + 1)) since <= since + 1'b1;
  end

  a_r9_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && locked) |=> $stable(guard));
  a_r7_mode_key: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ctl_wr && wdata[7:3] == 5'b11000)) |=> $stable(scheme_mode));
  a_r8_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (scheme_mode == 2'b00) |-> !locked);
  a_r3_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wdata[7:3] == 5'b10011 && scheme_mode != 2'b00) |=> !locked);
  a_r6_relock: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wdata[7:3] == 5'b10101 && scheme_mode != 2'b00) |=> locked);
  a_r4_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (since >= SW'(WINDOW) && scheme_mode != 2'b00) |-> locked);
endmodule

bind wprot_reg wprot_reg_chk #(.WINDOW(WINDOW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .ndiv(ndiv), .kdiv(kdiv), .wdog_en(wdog_en), .sd_en(sd_en), .pd_en(pd_en),
  .locked(locked), .scheme_mode(scheme_mode)
);

// File: tb/tb_wprot_reg.sv
module tb_wprot_reg;
  localparam int WIN = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [2:0] ndiv;
  logic [1:0] kdiv, scheme_mode;
  logic wdog_en, sd_en, pd_en, locked;

  int checks = 0, fails = 0;
  logic [1:0] m_mode = 2'b11;
  logic       m_open = 1'b0;
  int         m_left = 0;
  logic [7:0] m_guard = 8'h00;

  always #10 clk = ~clk;

  wprot_reg #(.WINDOW(WIN)) dut (.*);

  function automatic logic m_locked();
    return (m_mode != 2'b00) && !m_open;
  endfunction

  function automatic logic [7:0] m_read(input logic a);
    return a ? m_guard : {5'b00000, m_locked(), m_mode};
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic a, input logic [7:0] d, input string tag);
    logic lk;
    logic [1:0] om;
    wr_en = w; rd_en = r; addr = a; wdata = d;
    #1;
    if (r) chk({tag, " read"}, rdata, m_read(a));
    else   chk("R2 idle rdata", rdata, 8'h00);
    @(posedge clk);
    lk = m_locked(); om = m_mode;
    if (m_open) begin
      if (m_left == 0) m_open = 1'b0; else m_left--;
    end
    if (w && !a) begin
      if (d[7:3] == 5'b11000) m_mode = d[1:0];
      if (d[7:3] == 5'b10011 && om != 2'b00) begin m_open = 1'b1; m_left = WIN - 1; end
      if (d[7:3] == 5'b10101) m_open = 1'b0;
    end
    if (w && a && !lk) m_guard = d;
    @(negedge clk);
    chk({tag, " locked"}, {7'd0, locked}, {7'd0, m_locked()});
    chk({tag, " mode"}, {6'd0, scheme_mode}, {6'd0, m_mode});
    chk({tag, " guard"}, {ndiv, kdiv, wdog_en, sd_en, pd_en}, m_guard);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 8'h00, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_en = 1'b1; addr = 1'b0; #1;
    chk("R1 ctrl reset", rdata, 8'h07);
    addr = 1'b1; #1;
    chk("R1 guard reset", rdata, 8'h00);
    rd_en = 1'b0;

    step(1'b1, 1'b0, 1'b1, 8'hA5, "R9 locked write");
    step(1'b0, 1'b1, 1'b1, 8'h00, "R9 readback");
    step(1'b1, 1'b0, 1'b0, 8'b10110_000, "R10 stray key");
    step(1'b1, 1'b0, 1'b0, 8'b11111_000, "R7 mode no key");
    step(1'b0, 1'b1, 1'b0, 8'h00, "R2 ctrl read");

    step(1'b1, 1'b0, 1'b0, 8'b10011_000, "R3 unlock");
    step(1'b1, 1'b0, 1'b1, 8'h5A, "R3 first edge write");
    chk("R3 guard accepted", {ndiv, kdiv, wdog_en, sd_en, pd_en}, 8'h5A);
    idle(WIN - 2, "R3 window");
    step(1'b1, 1'b0, 1'b1, 8'h3C, "R3 last edge write");
    chk("R3 last edge accepted", {ndiv, kdiv, wdog_en, sd_en, pd_en}, 8'h3C);
    chk("R4 locked after window", {7'd0, locked}, 8'h01);

    step(1'b1, 1'b0, 1'b0, 8'b10011_000, "R4 unlock");
    idle(WIN, "R4 wait");
    step(1'b1, 1'b0, 1'b1, 8'hFF, "R4 late write");
    chk("R4 late write ignored", {ndiv, kdiv, wdog_en, sd_en, pd_en}, 8'h3C);

    step(1'b1, 1'b0, 1'b0, 8'b10011_000, "R5 unlock");
    idle(WIN - 4, "R5 wait");
    step(1'b1, 1'b0, 1'b0, 8'b10011_000, "R5 re-unlock");
    idle(WIN - 1, "R5 wait2");
    step(1'b1, 1'b0, 1'b1, 8'h81, "R5 restarted write");
    chk("R5 restart accepted", {ndiv, kdiv, wdog_en, sd_en, pd_en}, 8'h81);

    step(1'b1, 1'b0, 1'b0, 8'b10011_000, "R6 unlock");
    step(1'b1, 1'b0, 1'b0, 8'b10101_000, "R6 relock");
    chk("R6 status set", {7'd0, locked}, 8'h01);
    step(1'b1, 1'b0, 1'b1, 8'h11, "R6 write after relock");
    chk("R6 write ignored", {ndiv, kdiv, wdog_en, sd_en, pd_en}, 8'h81);

    step(1'b1, 1'b0, 1'b0, 8'b11000_000, "R8 disarm");
    chk("R8 status clear", {7'd0, locked}, 8'h00);
    step(1'b1, 1'b0, 1'b1, 8'h22, "R8 free write");
    chk("R8 write accepted", {ndiv, kdiv, wdog_en, sd_en, pd_en}, 8'h22);
    step(1'b1, 1'b0, 1'b0, 8'b10011_000, "R11 unlock while disarmed");
    step(1'b1, 1'b0, 1'b0, 8'b11000_001, "R11 arm mode 01");
    chk("R11 locked after arm", {7'd0, locked}, 8'h01);
    step(1'b1, 1'b0, 1'b0, 8'b11000_010, "R8 mode 10");
    step(1'b1, 1'b0, 1'b1, 8'h44, "R8 mode 10 blocks");

    for (int i = 0; i < 3000; i++) begin
      int op;
      logic [7:0] d;
      op = int'($urandom_range(0, 9));
      d = 8'($urandom);
      case (op)
        0: step(1'b1, 1'b0, 1'b0, {5'b10011, d[2:0]}, "R3 rnd unlock");
        1: step(1'b1, 1'b0, 1'b0, {5'b10101, d[2:0]}, "R6 rnd relock");
        2: step(1'b1, 1'b0, 1'b0, {5'b11000, d[2:0]}, "R7 rnd mode");
        3: step(1'b1, 1'b0, 1'b0, d, "R10 rnd ctrl");
        4, 5: step(1'b1, 1'b0, 1'b1, d, "R9 rnd guard");
        6: step(1'b0, 1'b1, 1'b0, d, "R2 rnd ctrl read");
        7: step(1'b0, 1'b1, 1'b1, d, "R2 rnd guard read");
        default: idle(int'($urandom_range(1, 20)), "R4 rnd idle");
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule